// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. It has no dead cycles when the bus changes direction. Every command is captured on a rising clock edge. The data for that command, whether read or write, moves exactly two active edges later. Reads and writes can therefore be issued back to back in any mix, and the data bus stays fully used. Each word is 36 bits, split into four 9-bit byte lanes. Each lane has its own write enable.

A single loaded address can be extended into a 4-beat burst by advance cycles. A static mode pin selects linear or interleaved beat order. A clock-enable pin freezes the whole device. Three chip-select inputs gate the start of new commands. Beats already in the pipeline still finish after a deselect. The bidirectional data bus is split into an input port, an output port and a drive-enable port. An asynchronous output-enable pin can force the driver off at any time.

Top module: `zbt_sram`

## Requirements
- R1: A read command captured at active edge k places the addressed word on `dq_out` after active edge k+2, with `dq_oe` high until the next active edge. A write command captured at edge k stores `dq_in` as sampled at active edge k+2.
- R2: Commands may alternate between read and write on every cycle with no idle cycle, and every transfer lands on its own address.
- R3: While `cke_n` is high, every synchronous input is ignored and all state holds, including the pipeline, the burst counter, `dq_out` and `dq_oe`.
- R4: The device is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. On a load cycle (`ld_n`=0) without selection, no command starts and any open burst ends. Transfers already in flight still complete.
- R5: `dq_oe` is low after active edge k+2 when the cycle at edge k carried a write or no command (deselect or ended burst).
- R6: In linear order (`burst_linear`=1), beat n of a burst uses low address bits (start + n) mod 4.
- R7: In interleaved order (`burst_linear`=0), beat n uses low address bits start XOR n.
- R8: A burst changes only the two low address bits. Advancing past the fourth beat wraps to the start offset.
- R9: An advance cycle (`ld_n`=1) repeats the read/write type of the loaded command and ignores `wr_n`.
- R10: Lane i is bits [9i+8:9i] of the word, parity bit on top. It is written only when `lane_we_n[i]` is low on the cycle that issues that beat, load or advance.
- R11: `oe_n` high forces `dq_oe` low immediately, without a clock edge. Lowering it restores the drive of a pending read.
- R12: While `rst_n` is low and after it is released, no transfer is pending and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset of pipeline and burst state, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls the device |
| ld_n | input | 1 | Low: load new address and command; high: advance burst |
| wr_n | input | 1 | Low: write, high: read (load cycles only) |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| burst_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data bus |
| dq_out | output | 36 | Read data bus |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Two functions can fall in the same cycle. One is a chip deselect, which ends a burst at the command stage. The other is an earlier burst beat still finishing its data phase. The bench opens a read burst, deselects on the third cycle and then sends further advance cycles. It checks that the beats already issued still appear on `dq_out` and that the advances after the deselect produce no drive. A second collision puts a stalled cycle on top of a read data phase and a pending write command. The held output and the untouched memory word show that the stall won.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
   localparam int LANE_CNT  = 4;
   localparam int LANE_BITS = 9;
   localparam int WORD_BITS = LANE_CNT * LANE_BITS;
   localparam int BEATS     = 4;
   localparam int BEAT_BITS = $clog2(BEATS);
   typedef enum logic {ORD_INTERLEAVE = 1'b0, ORD_LINEAR = 1'b1} burst_order_e;
endpackage

// File: rtl/zbt_beat_offset.sv
`timescale 1ns/1ps
module zbt_beat_offset #(
   parameter int OW = 2
) (
   input  logic [OW-1:0] start,
   input  logic [OW-1:0] beat,
   input  logic          linear,
   output logic [OW-1:0] offset
);
   logic [OW-1:0] lin_ofs;
   logic [OW-1:0] ilv_ofs;

   assign lin_ofs = start + beat;   // wraps modulo 2**OW
   assign ilv_ofs = start ^ beat;
   assign offset  = (linear == zbt_pkg::ORD_LINEAR) ? lin_ofs : ilv_ofs;
endmodule

// File: rtl/zbt_lane_array.sv
`timescale 1ns/1ps
module zbt_lane_array #(
   parameter int AW    = 6,
   parameter int LANES = 4,
   parameter int LW    = 9
) (
   input  logic                  clk,
   input  logic [LANES-1:0]      wr_en,
   input  logic [AW-1:0]         addr,
   input  logic [LANES*LW-1:0]   wdata,
   output logic [LANES*LW-1:0]   rdata
);
   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en[g]) cells[addr] <= wdata[g*LW +: LW];
      end
      assign rdata[g*LW +: LW] = cells[addr];
   end
endmodule

// File: rtl/zbt_cmd_stage.sv
`timescale 1ns/1ps
module zbt_cmd_stage #(
   parameter int AW    = 6,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke_n,
   input  logic             ld_n,
   input  logic             wr_n,
   input  logic             sel1_n,
   input  logic             sel2,
   input  logic             sel3_n,
   input  logic             linear,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] lane_we_n,
   output logic             op_valid,
   output logic             op_write,
   output logic [AW-1:0]    op_addr,
   output logic [LANES-1:0] op_lanes
);
   localparam int OW = zbt_pkg::BEAT_BITS;
   localparam int PW = AW - OW;

   if (AW <= OW) begin : g_bad_aw
      $error("zbt_cmd_stage: AW must exceed the burst offset width");
   end

   logic          selected;
   logic          burst_on;
   logic          burst_wr;
   logic [OW-1:0] start_ofs;
   logic [OW-1:0] beat;
   logic [OW-1:0] beat_nx;
   logic [OW-1:0] ofs_nx;
   logic [PW-1:0] page;

   assign selected = !sel1_n && sel2 && !sel3_n;
   assign beat_nx  = beat + OW'(1);

   zbt_beat_offset #(.OW(OW)) u_ofs (
      .start  (start_ofs),
      .beat   (beat_nx),
      .linear (linear),
      .offset (ofs_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_on  <= 1'b0;
         burst_wr  <= 1'b0;
         start_ofs <= '0;
         beat      <= '0;
         page      <= '0;
         op_valid  <= 1'b0;
         op_write  <= 1'b0;
         op_addr   <= '0;
         op_lanes  <= '0;
      end else if (!cke_n) begin
         if (!ld_n) begin
            if (selected) begin
               burst_on  <= 1'b1;
               burst_wr  <= !wr_n;
               start_ofs <= addr[OW-1:0];
               beat      <= '0;
               page      <= addr[AW-1:OW];
               op_valid  <= 1'b1;
               op_write  <= !wr_n;
               op_addr   <= addr;
               op_lanes  <= ~lane_we_n;
            end else begin
               burst_on  <= 1'b0;
               op_valid  <= 1'b0;
            end
         end else if (burst_on) begin
            beat     <= beat_nx;
            op_valid <= 1'b1;
            op_write <= burst_wr;
            op_addr  <= {page, ofs_nx};
            op_lanes <= ~lane_we_n;
         end else begin
            op_valid <= 1'b0;
         end
      end
   end

   // R3: a stalled cycle leaves the command stage untouched
   a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> $stable({op_valid, op_write, op_addr, op_lanes, beat, burst_on}));

   // R4: a load cycle without full selection issues nothing
   a_r4_desel_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && (sel1_n || !sel2 || sel3_n)) |=> !op_valid);

   // R8: burst beats keep the upper address bits
   a_r8_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && ld_n && burst_on) |=> (op_addr[AW-1:OW] == $past(op_addr[AW-1:OW])));

   // R9: an advance beat repeats the loaded operation type
   a_r9_type_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && ld_n && burst_on) |=> (op_valid && op_write == $past(op_write)));
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cke_n,
   input  logic          ld_n,
   input  logic          wr_n,
   input  logic          sel1_n,
   input  logic          sel2,
   input  logic          sel3_n,
   input  logic          burst_linear,
   input  logic [AW-1:0] addr,
   input  logic [3:0]    lane_we_n,
   input  logic          oe_n,
   input  logic [35:0]   dq_in,
   output logic [35:0]   dq_out,
   output logic          dq_oe
);
   import zbt_pkg::*;
   localparam int LANES = LANE_CNT;
   localparam int WW    = WORD_BITS;

   if (WW != 36 || LANES != 4) begin : g_bad_word
      $error("zbt_sram: word layout must be four 9-bit lanes");
   end

   logic             op_valid, op_write;
   logic [AW-1:0]    op_addr;
   logic [LANES-1:0] op_lanes;

   logic             s2_valid, s2_write;
   logic [AW-1:0]    s2_addr;
   logic [LANES-1:0] s2_lanes;
   logic [LANES-1:0] mem_wr;
   logic [WW-1:0]    mem_rdata;
   logic [WW-1:0]    rd_q;
   logic             rd_drive;

   zbt_cmd_stage #(.AW(AW), .LANES(LANES)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke_n     (cke_n),
      .ld_n      (ld_n),
      .wr_n      (wr_n),
      .sel1_n    (sel1_n),
      .sel2      (sel2),
      .sel3_n    (sel3_n),
      .linear    (burst_linear),
      .addr      (addr),
      .lane_we_n (lane_we_n),
      .op_valid  (op_valid),
      .op_write  (op_write),
      .op_addr   (op_addr),
      .op_lanes  (op_lanes)
   );

   assign mem_wr = (!cke_n && s2_valid && s2_write) ? s2_lanes : '0;

   zbt_lane_array #(.AW(AW), .LANES(LANES), .LW(LANE_BITS)) u_mem (
      .clk   (clk),
      .wr_en (mem_wr),
      .addr  (s2_addr),
      .wdata (dq_in),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_write <= 1'b0;
         s2_addr  <= '0;
         s2_lanes <= '0;
         rd_drive <= 1'b0;
         rd_q     <= '0;
      end else if (!cke_n) begin
         s2_valid <= op_valid;
         s2_write <= op_write;
         s2_addr  <= op_addr;
         s2_lanes <= op_lanes;
         rd_drive <= s2_valid && !s2_write;
         if (s2_valid && !s2_write) rd_q <= mem_rdata;
      end
   end

   assign dq_out = rd_q;
   assign dq_oe  = rd_drive && !oe_n;

   // R5: a write data phase never drives the bus
   a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && s2_valid && s2_write) |=> !dq_oe);

   // R1: a read data phase drives the bus unless output enable is off
   a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && s2_valid && !s2_write) |=> (oe_n || dq_oe));

   // R3: a stall holds the output register
   a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> $stable(dq_out));
endmodule

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke_n = 1'b0;
   logic          ld_n = 1'b0;
   logic          wr_n = 1'b1;
   logic          sel1_n = 1'b1;
   logic          sel2 = 1'b1;
   logic          sel3_n = 1'b0;
   logic          burst_linear = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [3:0]    lane_we_n = 4'hF;
   logic          oe_n = 1'b0;
   logic [35:0]   dq_in = '0;
   logic [35:0]   dq_out;
   logic          dq_oe;

   int n_cmp = 0;
   int n_bad = 0;

   localparam logic [35:0] D1 = 36'hA_1234_5678;
   localparam logic [35:0] D2 = 36'h5_CAFE_0101;
   localparam logic [35:0] D3 = 36'h3_0F0F_F0F0;
   localparam logic [35:0] V0 = 36'h1_1111_0000;
   localparam logic [35:0] V1 = 36'h2_2222_0001;
   localparam logic [35:0] V2 = 36'h4_4444_0002;
   localparam logic [35:0] V3 = 36'h8_8888_0003;

   always #5 clk = ~clk;

   zbt_sram #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n), .wr_n(wr_n),
      .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .burst_linear(burst_linear),
      .addr(addr), .lane_we_n(lane_we_n), .oe_n(oe_n), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input logic ck, input logic ld, input logic wr,
                       input logic [AW-1:0] a, input logic [3:0] ben,
                       input logic [35:0] d);
      cke_n = ck; ld_n = ld; wr_n = wr; addr = a; lane_we_n = ben; dq_in = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input logic [35:0] d);
      sel1_n = 1'b1;
      tick(1'b0, 1'b0, 1'b1, '0, 4'hF, d);
      sel1_n = 1'b0;
   endtask

   task automatic wr_cmd(input logic [AW-1:0] a, input logic [3:0] ben, input logic [35:0] d);
      tick(1'b0, 1'b0, 1'b0, a, ben, d);
   endtask

   task automatic rd_cmd(input logic [AW-1:0] a, input logic [35:0] d);
      tick(1'b0, 1'b0, 1'b1, a, 4'hF, d);
   endtask

   task automatic adv(input logic wr, input logic [3:0] ben, input logic [35:0] d);
      tick(1'b0, 1'b1, wr, '0, ben, d);
   endtask

   task automatic read_one(input logic [AW-1:0] a, input logic [35:0] exp, input string req);
      rd_cmd(a, '0);
      idle('0);
      idle('0);
      check(req, dq_out, exp);
      check(req, 36'(dq_oe), 36'd1);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R12 oe in reset", 36'(dq_oe), 36'd0);
      rst_n = 1'b1;
      idle('0);
      idle('0);
      check("R12 oe after reset", 36'(dq_oe), 36'd0);
   endtask

   task automatic t_single;
      wr_cmd(6'd5, 4'h0, '0);
      idle('0);
      idle(D1);
      check("R5 no drive on write phase", 36'(dq_oe), 36'd0);
      rd_cmd(6'd5, '0);
      idle('0);
      idle('0);
      check("R1 read data", dq_out, D1);
      check("R1 read drive", 36'(dq_oe), 36'd1);
      idle('0);
      check("R5 no drive after deselect", 36'(dq_oe), 36'd0);
   endtask

   task automatic t_turn;
      wr_cmd(6'd10, 4'h0, '0);
      rd_cmd(6'd5, '0);
      wr_cmd(6'd11, 4'h0, D2);
      rd_cmd(6'd10, '0);
      check("R2 read between writes", dq_out, D1);
      check("R2 read drive", 36'(dq_oe), 36'd1);
      idle(D3);
      check("R2 write slot undriven", 36'(dq_oe), 36'd0);
      idle('0);
      check("R2 read after adjacent write", dq_out, D2);
      idle('0);
      read_one(6'd11, D3, "R2 second write landed");
   endtask

   task automatic t_burst_linear;
      burst_linear = 1'b1;
      wr_cmd(6'h12, 4'h0, '0);
      adv(1'b1, 4'h0, '0);
      adv(1'b1, 4'h0, V0);
      adv(1'b1, 4'h0, V1);
      idle(V2);
      check("R9 advance stays write", 36'(dq_oe), 36'd0);
      idle(V3);
      check("R9 advance stays write", 36'(dq_oe), 36'd0);
      read_one(6'h12, V0, "R6 beat0");
      read_one(6'h13, V1, "R6 beat1");
      read_one(6'h10, V2, "R8 beat2 wraps in page");
      read_one(6'h11, V3, "R6 beat3");
   endtask

   task automatic t_burst_interleave;
      burst_linear = 1'b0;
      rd_cmd(6'h11, '0);
      adv(1'b0, 4'hF, '0);
      adv(1'b0, 4'hF, '0);
      check("R7 beat0", dq_out, V3);
      adv(1'b0, 4'hF, '0);
      check("R7 beat1", dq_out, V2);
      adv(1'b0, 4'hF, '0);
      check("R7 beat2", dq_out, V1);
      idle('0);
      check("R7 beat3", dq_out, V0);
      idle('0);
      check("R8 fifth beat wraps to start", dq_out, V3);
      check("R9 advance stays read", 36'(dq_oe), 36'd1);
      idle('0);
      burst_linear = 1'b1;
   endtask

   task automatic t_lanes;
      wr_cmd(6'd20, 4'h0, '0);
      idle('0);
      idle({36{1'b1}});
      wr_cmd(6'd20, 4'b1010, '0);
      idle('0);
      idle('0);
      read_one(6'd20, {9'h1FF, 9'h000, 9'h1FF, 9'h000}, "R10 lanes 0 and 2 only");
      idle('0);
   endtask

   task automatic t_stall;
      rd_cmd(6'd5, '0);
      idle('0);
      idle('0);
      check("R3 pre-stall data", dq_out, D1);
      tick(1'b1, 1'b0, 1'b0, 6'd5, 4'h0, '0);
      check("R3 stall holds drive", 36'(dq_oe), 36'd1);
      check("R3 stall holds data", dq_out, D1);
      rd_cmd(6'd10, '0);
      tick(1'b1, 1'b0, 1'b1, '0, 4'hF, '0);
      idle('0);
      check("R3 stalled cycle adds no edge", 36'(dq_oe), 36'd0);
      idle('0);
      check("R3 read after stall", dq_out, D2);
      idle('0);
      idle('0);
      read_one(6'd5, D1, "R3 stalled write ignored");
      idle('0);
   endtask

   task automatic t_deselect;
      burst_linear = 1'b1;
      rd_cmd(6'h10, '0);
      adv(1'b1, 4'hF, '0);
      sel2 = 1'b0;
      tick(1'b0, 1'b0, 1'b1, '0, 4'hF, '0);
      sel2 = 1'b1;
      check("R4 pending beat0", dq_out, V2);
      adv(1'b1, 4'hF, '0);
      check("R4 pending beat1", dq_out, V3);
      check("R4 pending beat1 drive", 36'(dq_oe), 36'd1);
      adv(1'b1, 4'hF, '0);
      check("R4 deselect slot undriven", 36'(dq_oe), 36'd0);
      adv(1'b1, 4'hF, '0);
      check("R4 burst stopped", 36'(dq_oe), 36'd0);
      for (int k = 0; k < 3; k++) begin
         sel1_n = (k == 0);
         sel2   = (k != 1);
         sel3_n = (k == 2);
         rd_cmd(6'h10, '0);
         sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
         idle('0);
         idle('0);
         check("R4 single enable off", 36'(dq_oe), 36'd0);
      end
   endtask

   task automatic t_oe;
      rd_cmd(6'd10, '0);
      idle('0);
      idle('0);
      check("R11 drive before oe", 36'(dq_oe), 36'd1);
      oe_n = 1'b1;
      #1;
      check("R11 oe off immediately", 36'(dq_oe), 36'd0);
      oe_n = 1'b0;
      #1;
      check("R11 oe restored", 36'(dq_oe), 36'd1);
      idle('0);
   endtask

   initial begin
      #2_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_single();
      t_turn();
      t_burst_linear();
      t_burst_interleave();
      t_lanes();
      t_stall();
      t_deselect();
      t_oe();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule